// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block records bus activity for on-chip debugging. It watches two event streams, one from the main processor and one from a coprocessor. One stream is chosen by configuration, and a trace mode decides which of its events become entries in a circular trace buffer. A four-state sequencer moves one state forward on each accepted trigger pulse. When it reaches its last state the session is triggered. The alignment setting then decides whether the entries kept lie after the trigger, before it, or on both sides of it.

Two inputs gate the capture. A security input blocks all storage, but the sequencer and breakpoint requests keep working. A background-debug input hides the main processor's events and trigger pulses, while coprocessor traffic is still traced and can still trigger. Software controls the block through a single configuration write. After capture it reads the buffer oldest entry first through an index port.

Each stored entry is `{bus, kind, addr, data}`, from the top bit down. `bus` is 1 for the coprocessor, `kind` is the 2-bit event kind, `addr` is ADDR_W bits and `data` is DATA_W bits. For a change-of-flow event, `addr` holds the branch source and `data` holds its destination.

Top module: `dbg_trace_ctrl`

## Requirements
- R1: After reset, armed, done, cnt, seq_state, brk_cpu and brk_cop are all 0.
- R2: A configuration write sets the fields arm (bit 0), immediate trigger (bit 1), mode (bits 3:2), alignment (bits 5:4) and bus select (bit 6, 1 = coprocessor). In mode 0 only change-of-flow events (kind 3) are stored, with the entry layout given above. A write with arm = 1 empties the buffer and restarts the sequencer at state 0.
- R3: Mode 1 stores change-of-flow events like mode 0. It skips any event whose source address equals the source address of the most recently stored entry.
- R4: Mode 2 stores data cycles (kind 2) and change-of-flow events (kind 3). It skips free cycles (kind 0) and opcode fetches (kind 1).
- R5: Mode 3 stores only opcode fetches (kind 1), which carry the program counter in addr.
- R6: While armed, each cycle with an accepted trigger pulse moves seq_state one step from 0 toward 3. Reaching 3 is the trigger, and the state then holds. On that edge a one-cycle breakpoint pulse appears on brk_cop when the coprocessor bus is selected, or otherwise on brk_cpu.
- R7: With begin alignment (0), nothing is stored before the trigger. After the trigger, DEPTH entries are stored. On the edge that stores the last of them, armed clears and done sets.
- R8: With mid alignment (1), storing runs both before and after the trigger. After DEPTH/2 post-trigger entries, armed clears and done sets.
- R9: With end alignment (2 or 3), storing runs until the trigger. On the trigger edge armed clears and done sets, and later events are not stored.
- R10: The buffer wraps around and cnt saturates at DEPTH. Index 0 on rd_idx reads the oldest kept entry, and rd_data is valid one cycle after rd_idx is applied.
- R11: While secure is high, no entry is stored. The sequencer still advances and breakpoint pulses are still produced.
- R12: While bdm is high, main-processor events and trig_cpu are ignored and brk_cpu stays low. Coprocessor events are still stored, trig_cop still advances the sequencer, and brk_cop still pulses. Raising bdm leaves armed unchanged.
- R13: A write with the immediate trigger bit set moves an armed sequencer straight to state 3 on the next edge, with no trigger pulse needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration fields (see R2) |
| secure | input | 1 | Device secure; blocks storage |
| bdm | input | 1 | Background debug active |
| cpu_vld | input | 1 | Main-processor event valid |
| cpu_kind | input | 2 | Main-processor event kind |
| cpu_addr | input | ADDR_W | Main-processor address or branch source |
| cpu_data | input | DATA_W | Main-processor data or branch destination |
| cop_vld | input | 1 | Coprocessor event valid |
| cop_kind | input | 2 | Coprocessor event kind |
| cop_addr | input | ADDR_W | Coprocessor address or branch source |
| cop_data | input | DATA_W | Coprocessor data or branch destination |
| trig_cpu | input | 1 | Trigger pulse from the main-processor side |
| trig_cop | input | 1 | Trigger pulse from the coprocessor side |
| rd_idx | input | log2(DEPTH) | Read index, 0 = oldest |
| rd_data | output | 3+ADDR_W+DATA_W | Entry at rd_idx, one cycle later |
| cnt | output | log2(DEPTH)+1 | Number of valid entries |
| armed | output | 1 | Session armed |
| done | output | 1 | Session completed |
| seq_state | output | 2 | Sequencer state |
| brk_cpu | output | 1 | Breakpoint request to the main processor |
| brk_cop | output | 1 | Breakpoint request to the coprocessor |

## Verification
The bench builds the block with DEPTH = 8 and 16-bit address and data. The small depth lets a handful of events wrap the buffer and saturate cnt. It also makes the begin and mid windows, 8 and 4 post-trigger entries, short enough to count exactly. Under these sizes the oldest-first read order after a wrap, the disarm edge in each alignment, and the difference between mid and begin retention can all be checked entry by entry.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;
  typedef enum logic [1:0] {
    TM_FLOW   = 2'd0,
    TM_LOOP   = 2'd1,
    TM_DETAIL = 2'd2,
    TM_PC     = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    AL_BEGIN = 2'd0,
    AL_MID   = 2'd1,
    AL_END   = 2'd2,
    AL_END2  = 2'd3
  } talign_e;

  localparam logic [1:0] K_FREE    = 2'd0;
  localparam logic [1:0] K_FETCH   = 2'd1;
  localparam logic [1:0] K_DATA    = 2'd2;
  localparam logic [1:0] K_COF     = 2'd3;
  localparam logic [1:0] SEQ_FINAL = 2'd3;
endpackage

// File: rtl/dbg_trace_filter.sv
module dbg_trace_filter
  import dbg_trace_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  tmode_e            mode,
  input  logic              vld,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] last_src,
  input  logic              last_vld,
  output logic              keep
);
  always_comb begin
    unique case (mode)
      TM_FLOW:   keep = vld && (kind == K_COF);
      TM_LOOP:   keep = vld && (kind == K_COF) && !(last_vld && (addr == last_src));
      TM_DETAIL: keep = vld && ((kind == K_DATA) || (kind == K_COF));
      default:   keep = vld && (kind == K_FETCH);
    endcase
  end
endmodule

// File: rtl/dbg_trace_seq.sv
module dbg_trace_seq
  import dbg_trace_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm_set,
  input  logic       arm_clr,
  input  logic       step,
  input  logic       imm,
  input  talign_e    align,
  input  logic       store,
  input  logic       sel_cop,
  input  logic       bdm,
  output logic       armed,
  output logic       trig,
  output logic       done,
  output logic [1:0] state,
  output logic       brk_cpu,
  output logic       brk_cop
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] post_cnt;
  logic [CW-1:0] post_last;
  logic          end_al;

  assign end_al    = (align == AL_END) || (align == AL_END2);
  assign post_last = (align == AL_BEGIN) ? CW'(DEPTH - 1) : CW'(DEPTH / 2 - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      trig     <= 1'b0;
      done     <= 1'b0;
      state    <= 2'd0;
      post_cnt <= '0;
      brk_cpu  <= 1'b0;
      brk_cop  <= 1'b0;
    end else begin
      brk_cpu <= 1'b0;
      brk_cop <= 1'b0;
      if (arm_set) begin
        armed    <= 1'b1;
        done     <= 1'b0;
        trig     <= 1'b0;
        state    <= 2'd0;
        post_cnt <= '0;
      end else if (arm_clr) begin
        armed <= 1'b0;
      end else if (armed) begin
        if (!trig && (step || imm)) begin
          if (imm || (state == 2'd2)) begin
            state   <= SEQ_FINAL;
            trig    <= 1'b1;
            brk_cop <= sel_cop;
            brk_cpu <= !sel_cop && !bdm;
            if (end_al) begin
              armed <= 1'b0;
              done  <= 1'b1;
            end
          end else begin
            state <= state + 2'd1;
          end
        end
        if (trig && store) begin
          post_cnt <= post_cnt + 1'b1;
          if (post_cnt == post_last) begin
            armed <= 1'b0;
            done  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbg_trace_buf.sv
module dbg_trace_buf #(
  parameter int ENT_W = 35,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       we,
  input  logic [ENT_W-1:0]           wdata,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [ENT_W-1:0]           rd_data,
  output logic [$clog2(DEPTH):0]     cnt
);
  localparam int AW = $clog2(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    raddr;

  assign raddr = wptr - cnt[AW-1:0] + rd_idx;

  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
    rd_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      cnt  <= '0;
    end else if (we) begin
      wptr <= wptr + 1'b1;
      if (cnt != (AW + 1)'(DEPTH)) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dbg_trace_ctrl.sv
module dbg_trace_ctrl
  import dbg_trace_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_wr,
  input  logic [7:0]                  cfg_wdata,
  input  logic                        secure,
  input  logic                        bdm,
  input  logic                        cpu_vld,
  input  logic [1:0]                  cpu_kind,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           cpu_data,
  input  logic                        cop_vld,
  input  logic [1:0]                  cop_kind,
  input  logic [ADDR_W-1:0]           cop_addr,
  input  logic [DATA_W-1:0]           cop_data,
  input  logic                        trig_cpu,
  input  logic                        trig_cop,
  input  logic [$clog2(DEPTH)-1:0]    rd_idx,
  output logic [2+ADDR_W+DATA_W:0]    rd_data,
  output logic [$clog2(DEPTH):0]      cnt,
  output logic                        armed,
  output logic                        done,
  output logic [1:0]                  seq_state,
  output logic                        brk_cpu,
  output logic                        brk_cop
);
  localparam int ENT_W = 3 + ADDR_W + DATA_W;

  tmode_e            mode_q;
  talign_e           align_q;
  logic              sel_q;
  logic              imm_q;
  logic              arm_set, arm_clr;
  logic              ev_vld;
  logic [1:0]        ev_kind;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;
  logic [ADDR_W-1:0] last_src;
  logic              last_vld;
  logic              keep, win, store, step, trig;

  assign arm_set = cfg_wr && cfg_wdata[0];
  assign arm_clr = cfg_wr && !cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= TM_FLOW;
      align_q <= AL_BEGIN;
      sel_q   <= 1'b0;
      imm_q   <= 1'b0;
    end else begin
      imm_q <= cfg_wr && cfg_wdata[1];
      if (cfg_wr) begin
        mode_q  <= tmode_e'(cfg_wdata[3:2]);
        align_q <= talign_e'(cfg_wdata[5:4]);
        sel_q   <= cfg_wdata[6];
      end
    end
  end

  assign ev_vld  = sel_q ? cop_vld  : (cpu_vld && !bdm);
  assign ev_kind = sel_q ? cop_kind : cpu_kind;
  assign ev_addr = sel_q ? cop_addr : cpu_addr;
  assign ev_data = sel_q ? cop_data : cpu_data;
  assign step    = trig_cop || (trig_cpu && !bdm);

  dbg_trace_filter #(.ADDR_W(ADDR_W)) u_filter (
    .mode(mode_q), .vld(ev_vld), .kind(ev_kind), .addr(ev_addr),
    .last_src(last_src), .last_vld(last_vld), .keep(keep)
  );

  assign win   = armed && !secure && !cfg_wr && ((align_q != AL_BEGIN) || trig);
  assign store = win && keep;

  always_ff @(posedge clk) begin
    if (rst || arm_set) begin
      last_vld <= 1'b0;
      last_src <= '0;
    end else if (store) begin
      last_vld <= 1'b1;
      last_src <= ev_addr;
    end
  end

  dbg_trace_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .arm_set(arm_set), .arm_clr(arm_clr), .step(step),
    .imm(imm_q), .align(align_q), .store(store), .sel_cop(sel_q), .bdm(bdm),
    .armed(armed), .trig(trig), .done(done), .state(seq_state),
    .brk_cpu(brk_cpu), .brk_cop(brk_cop)
  );

  dbg_trace_buf #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .clr(arm_set), .we(store),
    .wdata({sel_q, ev_kind, ev_addr, ev_data}),
    .rd_idx(rd_idx), .rd_data(rd_data), .cnt(cnt)
  );
endmodule

// File: rtl/dbg_trace_chk.sv
module dbg_trace_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_wr,
  input logic                   secure,
  input logic                   bdm,
  input logic [$clog2(DEPTH):0] cnt,
  input logic                   armed,
  input logic                   done,
  input logic [1:0]             seq_state,
  input logic                   brk_cpu,
  input logic                   brk_cop
);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= ($clog2(DEPTH) + 1)'(DEPTH));

  p_secure_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (secure && !cfg_wr) |=> (cnt == $past(cnt)));

  p_brk_bdm_r12: assert property (@(posedge clk) disable iff (rst)
    bdm |=> !brk_cpu);

  p_brk_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(brk_cpu && brk_cop));

  p_final_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && (seq_state == 2'd3) && !cfg_wr) |=> (seq_state == 2'd3));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !armed);
endmodule

bind dbg_trace_ctrl dbg_trace_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .secure(secure), .bdm(bdm),
  .cnt(cnt), .armed(armed), .done(done), .seq_state(seq_state),
  .brk_cpu(brk_cpu), .brk_cop(brk_cop)
);

// File: tb/dbg_trace_ctrl_bench.sv
module dbg_trace_ctrl_bench;
  localparam int A = 16;
  localparam int D = 16;
  localparam int N = 8;
  localparam int AW = $clog2(N);
  localparam int EW = 3 + A + D;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          secure = 1'b0, bdm = 1'b0;
  logic          cpu_vld = 1'b0, cop_vld = 1'b0;
  logic [1:0]    cpu_kind = '0, cop_kind = '0;
  logic [A-1:0]  cpu_addr = '0, cop_addr = '0;
  logic [D-1:0]  cpu_data = '0, cop_data = '0;
  logic          trig_cpu = 1'b0, trig_cop = 1'b0;
  logic [AW-1:0] rd_idx = '0;
  logic [EW-1:0] rd_data;
  logic [AW:0]   cnt;
  logic          armed, done, brk_cpu, brk_cop;
  logic [1:0]    seq_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dbg_trace_ctrl #(.ADDR_W(A), .DATA_W(D), .DEPTH(N)) u_dbg_trace_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .secure(secure), .bdm(bdm),
    .cpu_vld(cpu_vld), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cop_vld(cop_vld), .cop_kind(cop_kind), .cop_addr(cop_addr), .cop_data(cop_data),
    .trig_cpu(trig_cpu), .trig_cop(trig_cop), .rd_idx(rd_idx), .rd_data(rd_data),
    .cnt(cnt), .armed(armed), .done(done), .seq_state(seq_state),
    .brk_cpu(brk_cpu), .brk_cop(brk_cop)
  );

  function automatic logic [EW-1:0] ent(bit bus, logic [1:0] k, logic [A-1:0] a, logic [D-1:0] d);
    return {bus, k, a, d};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ev(bit bus, logic [1:0] k, logic [A-1:0] a, logic [D-1:0] d);
    if (bus) begin cop_vld = 1'b1; cop_kind = k; cop_addr = a; cop_data = d; end
    else     begin cpu_vld = 1'b1; cpu_kind = k; cpu_addr = a; cpu_data = d; end
    @(negedge clk);
    cpu_vld = 1'b0; cop_vld = 1'b0;
  endtask

  task automatic pulse(bit c, bit p);
    trig_cpu = c; trig_cop = p;
    @(negedge clk);
    trig_cpu = 1'b0; trig_cop = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] i, output logic [EW-1:0] v);
    rd_idx = i;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 armed", 64'(armed), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 cnt", 64'(cnt), 0);
    chk("R1 state", 64'(seq_state), 0);
    chk("R1 brk", 64'({brk_cpu, brk_cop}), 0);
  endtask

  task automatic t_normal;
    logic [EW-1:0] v;
    cfg(8'h21);
    ev(0, 2'd1, 16'h0010, 16'h0);
    ev(0, 2'd2, 16'h0011, 16'h5);
    ev(0, 2'd3, 16'h0100, 16'h0200);
    ev(0, 2'd0, 16'h0, 16'h0);
    ev(0, 2'd3, 16'h0104, 16'h0300);
    chk("R2 cnt", 64'(cnt), 2);
    rd(0, v); chk("R2 entry0", 64'(v), 64'(ent(0, 2'd3, 16'h0100, 16'h0200)));
    rd(1, v); chk("R2 entry1", 64'(v), 64'(ent(0, 2'd3, 16'h0104, 16'h0300)));
    chk("R2 still armed", 64'(armed), 1);
  endtask

  task automatic t_loop;
    logic [EW-1:0] v;
    cfg(8'h25);
    ev(0, 2'd3, 16'h0050, 16'h1);
    ev(0, 2'd3, 16'h0050, 16'h2);
    ev(0, 2'd3, 16'h0060, 16'h3);
    ev(0, 2'd3, 16'h0050, 16'h4);
    chk("R3 cnt", 64'(cnt), 3);
    rd(1, v); chk("R3 entry1", 64'(v), 64'(ent(0, 2'd3, 16'h0060, 16'h3)));
    rd(2, v); chk("R3 entry2", 64'(v), 64'(ent(0, 2'd3, 16'h0050, 16'h4)));
  endtask

  task automatic t_detail;
    logic [EW-1:0] v;
    cfg(8'h29);
    ev(0, 2'd0, 16'h0, 16'h0);
    ev(0, 2'd1, 16'h0009, 16'h0);
    ev(0, 2'd2, 16'h0001, 16'h00AA);
    ev(0, 2'd3, 16'h0002, 16'h0003);
    chk("R4 cnt", 64'(cnt), 2);
    rd(0, v); chk("R4 entry0", 64'(v), 64'(ent(0, 2'd2, 16'h0001, 16'h00AA)));
  endtask

  task automatic t_purepc;
    logic [EW-1:0] v;
    cfg(8'h2D);
    ev(0, 2'd1, 16'h0040, 16'h0);
    ev(0, 2'd2, 16'h0041, 16'h7);
    ev(0, 2'd3, 16'h0041, 16'h90);
    ev(0, 2'd1, 16'h0042, 16'h0);
    chk("R5 cnt", 64'(cnt), 2);
    rd(1, v); chk("R5 entry1", 64'(v), 64'(ent(0, 2'd1, 16'h0042, 16'h0)));
  endtask

  task automatic t_end_wrap;
    logic [EW-1:0] v;
    cfg(8'h21);
    for (int i = 0; i < 10; i++) ev(0, 2'd3, 16'(i), 16'(i + 16'h100));
    chk("R10 cnt saturates", 64'(cnt), N);
    rd(0, v); chk("R10 oldest", 64'(v), 64'(ent(0, 2'd3, 16'd2, 16'h102)));
    rd(7, v); chk("R10 newest", 64'(v), 64'(ent(0, 2'd3, 16'd9, 16'h109)));
    pulse(1, 0); chk("R6 state1", 64'(seq_state), 1);
    pulse(1, 0); chk("R6 state2", 64'(seq_state), 2);
    chk("R6 no brk yet", 64'(brk_cpu), 0);
    pulse(1, 0);
    chk("R6 final", 64'(seq_state), 3);
    chk("R6 brk_cpu", 64'(brk_cpu), 1);
    chk("R9 disarmed", 64'(armed), 0);
    chk("R9 done", 64'(done), 1);
    @(negedge clk);
    chk("R6 brk one cycle", 64'(brk_cpu), 0);
    ev(0, 2'd3, 16'h0AAA, 16'h0BBB);
    chk("R9 no store after", 64'(cnt), N);
  endtask

  task automatic t_begin;
    logic [EW-1:0] v;
    cfg(8'h01);
    for (int i = 0; i < 3; i++) ev(0, 2'd3, 16'(i), 16'h0);
    chk("R7 nothing before trigger", 64'(cnt), 0);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    chk("R7 armed at trigger", 64'(armed), 1);
    chk("R7 brk_cpu", 64'(brk_cpu), 1);
    for (int i = 0; i < 7; i++) ev(0, 2'd3, 16'(16'h80 + i), 16'(i));
    chk("R7 armed before last", 64'(armed), 1);
    ev(0, 2'd3, 16'h0087, 16'd7);
    chk("R7 disarm", 64'(armed), 0);
    chk("R7 done", 64'(done), 1);
    ev(0, 2'd3, 16'h0099, 16'd9);
    chk("R7 cnt", 64'(cnt), N);
    rd(0, v); chk("R7 oldest", 64'(v), 64'(ent(0, 2'd3, 16'h0080, 16'd0)));
  endtask

  task automatic t_mid;
    logic [EW-1:0] v;
    cfg(8'h11);
    for (int i = 0; i < 5; i++) ev(0, 2'd3, 16'(16'h10 + i), 16'h0);
    chk("R8 pre stored", 64'(cnt), 5);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    for (int i = 0; i < 3; i++) ev(0, 2'd3, 16'(16'h20 + i), 16'h0);
    chk("R8 armed before half", 64'(armed), 1);
    ev(0, 2'd3, 16'h0023, 16'h0);
    chk("R8 disarm", 64'(armed), 0);
    chk("R8 done", 64'(done), 1);
    rd(0, v); chk("R8 oldest", 64'(v), 64'(ent(0, 2'd3, 16'h0011, 16'h0)));
    rd(3, v); chk("R8 last pre", 64'(v), 64'(ent(0, 2'd3, 16'h0014, 16'h0)));
    rd(4, v); chk("R8 first post", 64'(v), 64'(ent(0, 2'd3, 16'h0020, 16'h0)));
  endtask

  task automatic t_imm;
    cfg(8'h03);
    chk("R13 armed", 64'(armed), 1);
    chk("R13 state0", 64'(seq_state), 0);
    @(negedge clk);
    chk("R13 final", 64'(seq_state), 3);
    chk("R13 brk_cpu", 64'(brk_cpu), 1);
    ev(0, 2'd3, 16'h0033, 16'h0044);
    chk("R13 post store", 64'(cnt), 1);
  endtask

  task automatic t_secure;
    secure = 1'b1;
    cfg(8'h21);
    ev(0, 2'd3, 16'h0001, 16'h0002);
    ev(0, 2'd3, 16'h0003, 16'h0004);
    chk("R11 no store", 64'(cnt), 0);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    chk("R11 final", 64'(seq_state), 3);
    chk("R11 brk_cpu", 64'(brk_cpu), 1);
    chk("R11 done", 64'(done), 1);
    secure = 1'b0;
  endtask

  task automatic t_bdm;
    logic [EW-1:0] v;
    cfg(8'h21);
    bdm = 1'b1;
    @(negedge clk);
    chk("R12 stays armed", 64'(armed), 1);
    ev(0, 2'd3, 16'h0005, 16'h0006);
    chk("R12 cpu ignored", 64'(cnt), 0);
    pulse(1, 0);
    chk("R12 trig_cpu ignored", 64'(seq_state), 0);
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    chk("R12 cop trig final", 64'(seq_state), 3);
    chk("R12 no brk_cpu", 64'({brk_cpu, brk_cop}), 0);
    cfg(8'h61);
    ev(1, 2'd3, 16'h0077, 16'h0088);
    chk("R12 cop stored", 64'(cnt), 1);
    rd(0, v); chk("R12 cop entry", 64'(v), 64'(ent(1, 2'd3, 16'h0077, 16'h0088)));
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    chk("R12 brk_cop", 64'(brk_cop), 1);
    bdm = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_normal;
    t_loop;
    t_detail;
    t_purepc;
    t_end_wrap;
    t_begin;
    t_mid;
    t_imm;
    t_secure;
    t_bdm;
    repeat (2) @(negedge clk);
    summary;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule